// File: doc/BRIEF.md
# Burst-Limited DMA Request Controller

This block raises the DMA request for a parallel-port FIFO. The request is gated by four things: the DMA enable, a service flag held inside the block, the transfer direction and the FIFO fill state. Each falling edge of the active-low DMA acknowledge is one FIFO access. No address is involved. On that edge the block emits a one-cycle push or pop strobe toward the FIFO.

Consecutive acknowledged cycles are counted. Once the burst limit is reached, the request is forced low so the host bus can serve memory refresh. It stays low until the acknowledge has been released for a minimum number of clocks. A terminal count seen during an acknowledged cycle sets the service flag, which ends DMA, and pulses an interrupt-cause output for the interrupt logic.

The host can write the service flag directly. All inputs are sampled on the rising clock edge.

Top module: `dma_burst_ctrl`

## Requirements
- R1: `dreq_o` is 1 only when `dma_en_i` is 1 and the service flag `svc_o` is 0.
- R2: With `dir_i`=0 (host to FIFO), `dreq_o` additionally requires `fifo_full_i`=0. With `dir_i`=1 (FIFO to host), it requires `fifo_empty_i`=0.
- R3: An acknowledge cycle starts at the first clock edge that samples `ack_ni`=0 after it was 1. In the following cycle, one of two strobes is high for exactly one cycle, whether or not `dreq_o` is high: `push_o` when `dir_i`=0, or `pop_o` when `dir_i`=1.
- R4: Acknowledge cycles taken while `dreq_o` is high are counted. After BURST_MAX (default 32) consecutive counted cycles, `dreq_o` is 0 from the cycle after the last one's start. After only BURST_MAX-1 cycles it stays 1.
- R5: After the burst limit, `dreq_o` stays 0 until `ack_ni` has been sampled 1 on REL_CYC (default 2) consecutive edges. It may rise in the cycle after that.
- R6: The burst count returns to 0 in two cases: at any edge where `dreq_o` is 0, and when `ack_ni` is sampled 1 on IDLE_GAP (default 8) consecutive edges. After either, a full new burst of BURST_MAX cycles is allowed.
- R7: If `tc_i` is 1 at the edge that starts an acknowledge cycle, the service flag becomes 1 and `tc_irq_o` is 1 for exactly the following cycle. As a result `dreq_o` falls.
- R8: `svc_wr_i`=1 loads `svc_wdata_i` into the service flag. A terminal count on the same edge wins, and the flag becomes 1.
- R9: After reset, `svc_o`=1, `dreq_o`=0, and `push_o`, `pop_o` and `tc_irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | DMA enable |
| dir_i | input | 1 | 0: host to FIFO, 1: FIFO to host |
| fifo_full_i | input | 1 | FIFO full |
| fifo_empty_i | input | 1 | FIFO empty |
| ack_ni | input | 1 | DMA acknowledge, active low |
| tc_i | input | 1 | Terminal count from the host DMA controller |
| svc_wr_i | input | 1 | Host write strobe for the service flag |
| svc_wdata_i | input | 1 | Value written to the service flag |
| dreq_o | output | 1 | DMA request |
| push_o | output | 1 | One-cycle FIFO write strobe |
| pop_o | output | 1 | One-cycle FIFO read strobe |
| tc_irq_o | output | 1 | One-cycle terminal-count interrupt cause |
| svc_o | output | 1 | Service flag |

## Verification
A burst count that is off by one shows up at the ports as `dreq_o` falling one cycle early or late around the 31st and 32nd acknowledge. The bench probes both sides of that boundary. A count that fails to clear after a request drop or an idle gap stays hidden until a later burst, where the request falls before that burst has reached the limit. The bench therefore runs long follow-up bursts after each clearing event. A stuck release counter or hold state appears within two to three clocks as a request that returns too early or never returns. Strobe timing and direction are compared, cycle by cycle, against a queue of expected accesses.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;
  typedef enum logic {
    DIR_WR = 1'b0,
    DIR_RD = 1'b1
  } dma_dir_e;
endpackage

// File: rtl/dma_ack_mon.sv
module dma_ack_mon #(
  parameter int CNT_MAX = 8,
  localparam int RW = $clog2(CNT_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ack_ni,
  output logic          fall_o,
  output logic [RW-1:0] rel_cnt_o
);
  localparam logic [RW-1:0] RMAX = RW'(CNT_MAX);

  logic          ack_q;
  logic [RW-1:0] rel_q;

  assign fall_o    = ack_q & ~ack_ni;
  assign rel_cnt_o = rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b1;
      rel_q <= '0;
    end else begin
      ack_q <= ack_ni;
      if (!ack_ni)            rel_q <= '0;
      else if (rel_q != RMAX) rel_q <= rel_q + 1'b1;
    end
  end

  // R6: release run length never passes its saturation point
  a_r6_rel_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_q <= RMAX);
  // R3: a fall cannot repeat on back-to-back edges
  a_r3_fall_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/dma_burst_cnt.sv
module dma_burst_cnt #(
  parameter int BURST_MAX = 32,
  parameter int REL_CYC   = 2,
  parameter int IDLE_GAP  = 8,
  parameter int RW        = 4,
  localparam int CW = $clog2(BURST_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fall_i,
  input  logic          req_i,
  input  logic          ack_ni,
  input  logic [RW-1:0] rel_cnt_i,
  output logic          hold_o
);
  localparam logic [CW-1:0] LAST     = CW'(BURST_MAX - 1);
  localparam logic [RW-1:0] REL_LAST = RW'(REL_CYC - 1);
  localparam logic [RW-1:0] GAP_LAST = RW'(IDLE_GAP - 1);

  logic [CW-1:0] cnt_q;
  logic          hold_q;
  logic          limit_hit;
  logic          rel_done;
  logic          gap_done;

  assign limit_hit = fall_i & req_i & (cnt_q == LAST);
  assign rel_done  = ack_ni & (rel_cnt_i >= REL_LAST);
  assign gap_done  = ack_ni & (rel_cnt_i >= GAP_LAST);
  assign hold_o    = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      if (limit_hit)         hold_q <= 1'b1;
      else if (rel_done)     hold_q <= 1'b0;

      if (!req_i || limit_hit) cnt_q <= '0;
      else if (fall_i)         cnt_q <= cnt_q + 1'b1;
      else if (gap_done)       cnt_q <= '0;
    end
  end

  // R4: the count stays below the limit
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R4: reaching the limit always enters hold
  a_r4_hold_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_hit |=> hold_q);
  // R5: hold is never left while the acknowledge is held low
  a_r5_hold_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !ack_ni) |=> hold_q);
endmodule

// File: rtl/dma_svc_flag.sv
module dma_svc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic tc_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic svc_o,
  output logic tc_irq_o
);
  logic svc_q;
  logic irq_q;
  logic tc_hit;

  assign tc_hit   = fall_i & tc_i;
  assign svc_o    = svc_q;
  assign tc_irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_q <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      irq_q <= tc_hit;
      if (tc_hit)    svc_q <= 1'b1;
      else if (wr_i) svc_q <= wdata_i;
    end
  end

  // R7 / R8: terminal count sets the flag, host write cannot override
  a_r7_tc_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_hit |=> (svc_q && irq_q));
  // R7: interrupt cause is a single-cycle pulse
  a_r7_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl
  import dma_burst_pkg::*;
#(
  parameter int BURST_MAX = 32,
  parameter int REL_CYC   = 2,
  parameter int IDLE_GAP  = 8,
  localparam int RMAX = (IDLE_GAP > REL_CYC) ? IDLE_GAP : REL_CYC,
  localparam int RW   = $clog2(RMAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dma_en_i,
  input  logic dir_i,
  input  logic fifo_full_i,
  input  logic fifo_empty_i,
  input  logic ack_ni,
  input  logic tc_i,
  input  logic svc_wr_i,
  input  logic svc_wdata_i,
  output logic dreq_o,
  output logic push_o,
  output logic pop_o,
  output logic tc_irq_o,
  output logic svc_o
);
  dma_dir_e      dir;
  logic          fall;
  logic [RW-1:0] rel_cnt;
  logic          hold;
  logic          svc;
  logic          fifo_ok;
  logic          push_q;
  logic          pop_q;

  assign dir     = dma_dir_e'(dir_i);
  assign fifo_ok = (dir == DIR_WR) ? !fifo_full_i : !fifo_empty_i;
  assign dreq_o  = dma_en_i & ~svc & ~hold & fifo_ok;
  assign svc_o   = svc;
  assign push_o  = push_q;
  assign pop_o   = pop_q;

  dma_ack_mon #(.CNT_MAX(RMAX)) u_ack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_ni    (ack_ni),
    .fall_o    (fall),
    .rel_cnt_o (rel_cnt)
  );

  dma_burst_cnt #(
    .BURST_MAX (BURST_MAX),
    .REL_CYC   (REL_CYC),
    .IDLE_GAP  (IDLE_GAP),
    .RW        (RW)
  ) u_burst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (fall),
    .req_i     (dreq_o),
    .ack_ni    (ack_ni),
    .rel_cnt_i (rel_cnt),
    .hold_o    (hold)
  );

  dma_svc_flag u_svc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (fall),
    .tc_i     (tc_i),
    .wr_i     (svc_wr_i),
    .wdata_i  (svc_wdata_i),
    .svc_o    (svc),
    .tc_irq_o (tc_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_q <= 1'b0;
      pop_q  <= 1'b0;
    end else begin
      push_q <= fall & (dir == DIR_WR);
      pop_q  <= fall & (dir == DIR_RD);
    end
  end

  // R1: request needs enable and a clear service flag
  a_r1_req_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_o |-> (dma_en_i && !svc_o));
  // R5: no request during the post-burst hold
  a_r5_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |-> !dreq_o);
  // R3: at most one strobe at a time, each one cycle long
  a_r3_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({push_o, pop_o}));
  a_r3_strobe_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o || pop_o) |=> !(push_o || pop_o));
endmodule

// File: tb/dma_burst_ctrl_tb.sv
module dma_burst_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_en = 1'b0, dir = 1'b0, full = 1'b0, empty = 1'b0;
  logic ack_n = 1'b1, tc = 1'b0, svc_wr = 1'b0, svc_wd = 1'b0;
  logic dreq, push, pop, tc_irq, svc;

  int checks = 0;
  int fails = 0;
  bit exp_q[$];  // 0 = push, 1 = pop
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_burst_ctrl u_dut (
    .clk_i (clk), .rst_ni (rst_n), .dma_en_i (dma_en), .dir_i (dir),
    .fifo_full_i (full), .fifo_empty_i (empty), .ack_ni (ack_n), .tc_i (tc),
    .svc_wr_i (svc_wr), .svc_wdata_i (svc_wd), .dreq_o (dreq), .push_o (push),
    .pop_o (pop), .tc_irq_o (tc_irq), .svc_o (svc)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Scoreboard monitor (R3): every strobe must match the oldest expected access
  always @(negedge clk) begin
    if (rst_n && (push || pop)) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3: actual=strobe push=%0b pop=%0b expected=none", push, pop);
      end else begin
        bit k;
        k = exp_q.pop_front();
        if (push !== !k || pop !== k) begin
          fails++;
          $display("FAIL R3: actual push=%0b pop=%0b expected kind=%0b", push, pop, k);
        end
      end
    end
  end

  // One acknowledge cycle: low for one clock, high for one clock
  task automatic dma_cycle(input logic with_tc);
    ack_n = 1'b0;
    tc = with_tc;
    exp_q.push_back(dir);
    @(negedge clk);
    ack_n = 1'b1;
    tc = 1'b0;
    @(negedge clk);
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) dma_cycle(1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic svc_write(input logic v);
    svc_wr = 1'b1;
    svc_wd = v;
    @(negedge clk);
    svc_wr = 1'b0;
  endtask

  initial begin
    idle(2);
    chk("R9 svc", svc, 1'b1);
    chk("R9 dreq", dreq, 1'b0);
    chk("R9 strobe", push | pop, 1'b0);
    chk("R9 irq", tc_irq, 1'b0);
    rst_n = 1'b1;
    idle(2);

    // R1
    dma_en = 1'b1;
    @(negedge clk);
    chk("R1 svc set blocks", dreq, 1'b0);
    svc_write(1'b0);
    chk("R1 enabled", dreq, 1'b1);
    dma_en = 1'b0;
    @(negedge clk);
    chk("R1 disabled", dreq, 1'b0);
    dma_en = 1'b1;

    // R2
    full = 1'b1;
    @(negedge clk);
    chk("R2 wr full", dreq, 1'b0);
    empty = 1'b1;
    full = 1'b0;
    @(negedge clk);
    chk("R2 wr empty ok", dreq, 1'b1);
    dir = 1'b1;
    @(negedge clk);
    chk("R2 rd empty", dreq, 1'b0);
    empty = 1'b0;
    full = 1'b1;
    @(negedge clk);
    chk("R2 rd full ok", dreq, 1'b1);
    full = 1'b0;

    // R3: strobe without request
    dma_en = 1'b0;
    dir = 1'b0;
    dma_cycle(1'b0);
    dir = 1'b1;
    dma_cycle(1'b0);
    dma_en = 1'b1;
    idle(10);

    // R4 / R5
    dir = 1'b0;
    burst(31);
    chk("R4 31 cycles keep request", dreq, 1'b1);
    ack_n = 1'b0;
    exp_q.push_back(dir);
    @(negedge clk);
    chk("R4 drop after limit", dreq, 1'b0);
    idle(2);
    chk("R5 held while ack low", dreq, 1'b0);
    ack_n = 1'b1;
    @(negedge clk);
    chk("R5 one release clock", dreq, 1'b0);
    @(negedge clk);
    chk("R5 returns after release", dreq, 1'b1);

    // R6: clear by request drop
    idle(10);
    dir = 1'b1;
    burst(20);
    dma_en = 1'b0;
    @(negedge clk);
    dma_en = 1'b1;
    burst(31);
    chk("R6 cleared by drop", dreq, 1'b1);
    idle(10);

    // R6: clear by idle gap
    burst(20);
    idle(8);
    burst(31);
    chk("R6 cleared by idle gap", dreq, 1'b1);
    idle(10);

    // R7
    dma_cycle(1'b1);
    chk("R7 svc after tc", svc, 1'b1);
    chk("R7 dreq after tc", dreq, 1'b0);
    ack_n = 1'b0;
    tc = 1'b1;
    exp_q.push_back(dir);
    @(negedge clk);
    chk("R7 irq pulse", tc_irq, 1'b1);
    ack_n = 1'b1;
    tc = 1'b0;
    @(negedge clk);
    chk("R7 irq one cycle", tc_irq, 1'b0);

    // R8
    svc_write(1'b0);
    chk("R8 host clear", svc, 1'b0);
    svc_wr = 1'b1;
    svc_wd = 1'b0;
    ack_n = 1'b0;
    tc = 1'b1;
    exp_q.push_back(dir);
    @(negedge clk);
    svc_wr = 1'b0;
    ack_n = 1'b1;
    tc = 1'b0;
    chk("R8 tc wins", svc, 1'b1);
    svc_write(1'b1);
    chk("R8 host set", svc, 1'b1);

    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R3: actual=%0d missing strobes expected=0", exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule